// File: doc/BRIEF.md
# Three-Line General-Purpose Pin Port

This block gives a chip three general-purpose pins that software configures through a small byte-wide register window. One register holds the direction of each line. A line whose direction bit is 1 is an input. A line whose direction bit is 0 is an output. A second register holds the value each output line drives. A third register is read-only. It returns the level sampled on each pin, merged with the value looped back from every line that is set as an output.

Pin levels come from outside the clock domain. Each level crosses a two-flop synchronizer and is then captured into the sampled-input register. A change on an input pin only updates that sampled value. It never touches the configuration, the pins or any event line. Each pin leaves the block as a data bit plus an output enable, and the pad logic outside the block does the actual driving.

The register window decodes three byte addresses: 0x1D for direction, 0x1E for the sampled inputs and 0x1F for the output data. A write lands on the rising clock edge while the write strobe is high. Read data is a combinational function of the address.

Top module: `gpio3_port`

## Requirements
- R1: After reset the direction register reads 0x07, meaning every line is an input, the output register reads 0x00, and both `pin_oe` and `pin_out` are 3'b000.
- R2: A write to address 0x1D stores the data ANDed with 0x67. Bits 5 and 6 are kept as plain storage, and reading 0x1D returns the stored byte.
- R3: A write to address 0x1F stores the data ANDed with 0x07, and reading 0x1F returns the stored byte.
- R4: `pin_oe[i]` is 1 exactly when direction bit i is 0 (output). A direction bit of 1 makes line i an input.
- R5: `pin_out[i]` equals output bit i while line i is an output, and is 0 while line i is an input.
- R6: `pin_out` and `pin_oe` change only at the clock edge that ends a register write cycle. In every other cycle they hold their value.
- R7: Reading address 0x1E returns, in bits 2..0, the sampled input levels ORed with (NOT direction AND output data), and 0 in bits 7..3.
- R8: A level change on `pin_in` appears in the 0x1E read value after exactly three rising clock edges (two synchronizer stages plus the sample register), and not after two.
- R9: Writes to 0x1E or to any unmapped address leave direction, output data and pins unchanged. Reads of unmapped addresses return 0x00.
- R10: Changes on `pin_in` never alter the direction register, the output register, `pin_out` or `pin_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pin_in | input | 3 | Asynchronous pin levels from the pads |
| pin_out | output | 3 | Value to drive on each pin |
| pin_oe | output | 3 | Output enable for each pin, 1 means drive |

## Verification
Corrupt direction or output data is visible at once. `pin_oe` and `pin_out` are combinational copies of those registers, so a bad bit shows up in the same cycle. A read of 0x1D or 0x1F shows it in the next sampled cycle. A fault in the synchronizer or in the sample register only shows through the 0x1E read. It appears there three edges after the pin moves, so the bench watches both the second and the third edge. Faulty masking or faulty address decode shows up as extra bits or wrong bits in the read-back that follows the write.

// File: rtl/gpio3_pkg.sv
package gpio3_pkg;

   // Which register of the window an address selects.
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_DIR  = 2'd1,
      SEL_SMP  = 2'd2,
      SEL_DRV  = 2'd3
   } gpio_sel_e;

endpackage

// File: rtl/gpio3_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
module gpio3_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] stg [STAGES];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
         end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
         end
      end

      assign q = stg[STAGES-1];
   end

endmodule

// File: rtl/gpio3_regfile.sv
// Direction and output-data storage with write masks.
module gpio3_regfile #(
   parameter int unsigned     DATA_W    = 8,
   parameter logic [DATA_W-1:0] DIR_WMASK = 8'h67,
   parameter logic [DATA_W-1:0] DRV_WMASK = 8'h07,
   parameter logic [DATA_W-1:0] DIR_RST   = 8'h07,
   parameter logic [DATA_W-1:0] DRV_RST   = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_dir,
   input  logic              wr_drv,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] dir_q,
   output logic [DATA_W-1:0] drv_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q <= DIR_RST & DIR_WMASK;
      end else if (wr_dir) begin
         dir_q <= wdata & DIR_WMASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q <= DRV_RST & DRV_WMASK;
      end else if (wr_drv) begin
         drv_q <= wdata & DRV_WMASK;
      end
   end

endmodule

// File: rtl/gpio3_readmux.sv
// Read-data selection; the sample view merges loopback of output lines.
module gpio3_readmux
   import gpio3_pkg::*;
#(
   parameter int unsigned NUM_LINES = 3,
   parameter int unsigned DATA_W    = 8
) (
   input  gpio_sel_e             sel,
   input  logic [DATA_W-1:0]     dir_q,
   input  logic [DATA_W-1:0]     drv_q,
   input  logic [NUM_LINES-1:0]  smp_q,
   output logic [DATA_W-1:0]     rdata
);

   logic [NUM_LINES-1:0] merged;
   logic [DATA_W-1:0]    merged_ext;

   assign merged     = smp_q | (~dir_q[NUM_LINES-1:0] & drv_q[NUM_LINES-1:0]);
   assign merged_ext = DATA_W'(merged);

   always_comb begin
      case (sel)
         SEL_DIR: rdata = dir_q;
         SEL_DRV: rdata = drv_q;
         SEL_SMP: rdata = merged_ext;
         default: rdata = '0;
      endcase
   end

endmodule

// File: rtl/gpio3_port.sv
// Three-line general-purpose pin port behind a byte register window.
module gpio3_port
   import gpio3_pkg::*;
#(
   parameter int unsigned       NUM_LINES   = 3,
   parameter int unsigned       DATA_W      = 8,
   parameter int unsigned       ADDR_W      = 8,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] DIR_ADDR    = 8'h1D,
   parameter logic [ADDR_W-1:0] SMP_ADDR    = 8'h1E,
   parameter logic [ADDR_W-1:0] DRV_ADDR    = 8'h1F,
   parameter logic [DATA_W-1:0] DIR_WMASK   = 8'h67,
   parameter logic [DATA_W-1:0] DRV_WMASK   = 8'h07,
   parameter logic [DATA_W-1:0] DIR_RST     = 8'h07,
   parameter logic [DATA_W-1:0] DRV_RST     = 8'h00
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [DATA_W-1:0]    reg_wdata,
   output logic [DATA_W-1:0]    reg_rdata,
   input  logic [NUM_LINES-1:0] pin_in,
   output logic [NUM_LINES-1:0] pin_out,
   output logic [NUM_LINES-1:0] pin_oe
);

   localparam logic [DATA_W-1:0] LINE_MASK = DATA_W'((1 << NUM_LINES) - 1);

   // Elaboration-time parameter checks.
   if (NUM_LINES < 1 || NUM_LINES > DATA_W) begin : g_bad_lines
      $error("gpio3_port: NUM_LINES must lie in 1..DATA_W");
   end
   if ((DIR_WMASK & LINE_MASK) != LINE_MASK) begin : g_bad_dirmask
      $error("gpio3_port: direction mask must keep every line bit");
   end
   if ((DRV_WMASK & ~LINE_MASK) != '0) begin : g_bad_drvmask
      $error("gpio3_port: output mask must not exceed the line bits");
   end
   if (DIR_ADDR == SMP_ADDR || DIR_ADDR == DRV_ADDR || SMP_ADDR == DRV_ADDR) begin : g_bad_addr
      $error("gpio3_port: register addresses must be distinct");
   end

   gpio_sel_e            sel;
   logic                 wr_dir;
   logic                 wr_drv;
   logic [DATA_W-1:0]    dir_q;
   logic [DATA_W-1:0]    drv_q;
   logic [NUM_LINES-1:0] sync_q;
   logic [NUM_LINES-1:0] smp_q;

   always_comb begin
      if (reg_addr == DIR_ADDR)      sel = SEL_DIR;
      else if (reg_addr == SMP_ADDR) sel = SEL_SMP;
      else if (reg_addr == DRV_ADDR) sel = SEL_DRV;
      else                           sel = SEL_NONE;
   end

   assign wr_dir = reg_wr && (sel == SEL_DIR);
   assign wr_drv = reg_wr && (sel == SEL_DRV);

   gpio3_regfile #(
      .DATA_W    (DATA_W),
      .DIR_WMASK (DIR_WMASK),
      .DRV_WMASK (DRV_WMASK),
      .DIR_RST   (DIR_RST),
      .DRV_RST   (DRV_RST)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_dir (wr_dir),
      .wr_drv (wr_drv),
      .wdata  (reg_wdata),
      .dir_q  (dir_q),
      .drv_q  (drv_q)
   );

   gpio3_sync #(
      .WIDTH  (NUM_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (sync_q)
   );

   // Sample register: captures every line, whatever its direction.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smp_q <= '0;
      else        smp_q <= sync_q;
   end

   // Per-line pad control.
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      assign pin_oe[i]  = ~dir_q[i];
      assign pin_out[i] = ~dir_q[i] & drv_q[i];
   end

   gpio3_readmux #(
      .NUM_LINES (NUM_LINES),
      .DATA_W    (DATA_W)
   ) u_rd (
      .sel   (sel),
      .dir_q (dir_q),
      .drv_q (drv_q),
      .smp_q (smp_q),
      .rdata (reg_rdata)
   );

endmodule

// File: rtl/gpio3_port_chk.sv
// Property checker, bound into every gpio3_port instance.
module gpio3_port_chk #(
   parameter int unsigned       NUM_LINES = 3,
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h1D,
   parameter logic [ADDR_W-1:0] SMP_ADDR  = 8'h1E,
   parameter logic [ADDR_W-1:0] DRV_ADDR  = 8'h1F,
   parameter logic [DATA_W-1:0] DIR_WMASK = 8'h67,
   parameter logic [DATA_W-1:0] DRV_WMASK = 8'h07
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 reg_wr,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic [DATA_W-1:0]    reg_wdata,
   input logic [DATA_W-1:0]    dir_q,
   input logic [DATA_W-1:0]    drv_q,
   input logic [NUM_LINES-1:0] pin_out,
   input logic [NUM_LINES-1:0] pin_oe
);

   AST_DIR_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == DIR_ADDR) |=> (dir_q == ($past(reg_wdata) & DIR_WMASK))); // R2

   AST_DRV_WRITE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == DRV_ADDR) |=> (drv_q == ($past(reg_wdata) & DRV_WMASK))); // R3

   AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe == ~dir_q[NUM_LINES-1:0]); // R4

   AST_NO_DRIVE_ON_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_out & ~pin_oe) == '0); // R5

   AST_PINS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_wr |=> ($stable(pin_out) && $stable(pin_oe))); // R6

   AST_SMP_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == SMP_ADDR) |=> ($stable(dir_q) && $stable(drv_q))); // R9

endmodule

bind gpio3_port gpio3_port_chk #(
   .NUM_LINES (NUM_LINES),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .DIR_ADDR  (DIR_ADDR),
   .SMP_ADDR  (SMP_ADDR),
   .DRV_ADDR  (DRV_ADDR),
   .DIR_WMASK (DIR_WMASK),
   .DRV_WMASK (DRV_WMASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata),
   .dir_q     (dir_q),
   .drv_q     (drv_q),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/gpio3_port_bench.sv
module gpio3_port_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_addr = 8'h00;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic [2:0] pin_in = 3'b000;
   logic [2:0] pin_out;
   logic [2:0] pin_oe;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   always #10 clk = ~clk;

   gpio3_port u_gpio3_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .pin_in    (pin_in),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   // Vector: addr, wdata, expected direction, expected output, expected oe, expected pin_out
   localparam int NV = 11;
   localparam logic [37:0] VEC [NV] = '{
      {8'h1F, 8'hFF, 8'h07, 8'h07, 3'b000, 3'b000},
      {8'h1D, 8'h00, 8'h00, 8'h07, 3'b111, 3'b111},
      {8'h1D, 8'hFF, 8'h67, 8'h07, 3'b000, 3'b000},
      {8'h1F, 8'h05, 8'h67, 8'h05, 3'b000, 3'b000},
      {8'h1D, 8'h02, 8'h02, 8'h05, 3'b101, 3'b101},
      {8'h1F, 8'hFA, 8'h02, 8'h02, 3'b101, 3'b000},
      {8'h1E, 8'hFF, 8'h02, 8'h02, 3'b101, 3'b000},
      {8'h40, 8'hFF, 8'h02, 8'h02, 3'b101, 3'b000},
      {8'h1D, 8'h98, 8'h00, 8'h02, 3'b111, 3'b010},
      {8'h1F, 8'h06, 8'h00, 8'h06, 3'b111, 3'b110},
      {8'h1D, 8'h61, 8'h61, 8'h06, 3'b110, 3'b110}
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      reg_addr = a;
      #2;
      d = reg_rdata;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=<20000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [2:0] po, pe;

      // R1: reset state
      repeat (3) @(negedge clk);
      rd(8'h1D, v); chk("R1 dir reset", v, 8'h07);
      rd(8'h1F, v); chk("R1 out reset", v, 8'h00);
      chk("R1 oe reset", {5'b0, pin_oe}, 8'h00);
      chk("R1 pin reset", {5'b0, pin_out}, 8'h00);
      @(negedge clk); rst_n = 1'b1;

      // Table walk: R2 R3 R4 R5 R9
      for (int k = 0; k < NV; k++) begin
         wr(VEC[k][37:30], VEC[k][29:22]);
         rd(8'h1D, v); chk($sformatf("R2 dir vec%0d", k), v, VEC[k][21:14]);
         rd(8'h1F, v); chk($sformatf("R3 out vec%0d", k), v, VEC[k][13:6]);
         chk($sformatf("R4 oe vec%0d", k), {5'b0, pin_oe}, {5'b0, VEC[k][5:3]});
         chk($sformatf("R5 pin vec%0d", k), {5'b0, pin_out}, {5'b0, VEC[k][2:0]});
      end

      // R9: unmapped reads
      rd(8'h00, v); chk("R9 unmapped 00", v, 8'h00);
      rd(8'h20, v); chk("R9 unmapped 20", v, 8'h00);

      // R6: idle cycles keep pins steady
      po = pin_out; pe = pin_oe;
      repeat (5) @(negedge clk);
      chk("R6 pin idle", {5'b0, pin_out}, {5'b0, po});
      chk("R6 oe idle", {5'b0, pin_oe}, {5'b0, pe});

      // R8: latency, all inputs, no loopback
      wr(8'h1D, 8'h07);
      wr(8'h1F, 8'h05);
      pin_in = 3'b010;
      @(negedge clk); @(negedge clk);
      rd(8'h1E, v); chk("R8 two edges", v, 8'h00);
      @(negedge clk);
      rd(8'h1E, v); chk("R8 three edges", v, 8'h02);

      // R7: merge of sampled inputs and loopback
      wr(8'h1D, 8'h06);
      wr(8'h1F, 8'h01);
      rd(8'h1E, v); chk("R7 merge", v, 8'h03);
      pin_in = 3'b000;
      repeat (4) @(negedge clk);
      rd(8'h1E, v); chk("R7 loopback only", v, 8'h01);
      wr(8'h1F, 8'h00);
      pin_in = 3'b001;
      repeat (4) @(negedge clk);
      rd(8'h1E, v); chk("R7 input on output line", v, 8'h01);
      pin_in = 3'b000;
      repeat (4) @(negedge clk);
      rd(8'h1E, v); chk("R7 all low", v, 8'h00);

      // R10: input activity leaves configuration and pins alone
      wr(8'h1D, 8'h04);
      wr(8'h1F, 8'h03);
      po = pin_out; pe = pin_oe;
      for (int k = 0; k < 8; k++) begin
         pin_in = 3'(k);
         @(negedge clk);
      end
      repeat (4) @(negedge clk);
      rd(8'h1D, v); chk("R10 dir", v, 8'h04);
      rd(8'h1F, v); chk("R10 out", v, 8'h03);
      chk("R10 pin", {5'b0, pin_out}, {5'b0, po});
      chk("R10 oe", {5'b0, pin_oe}, {5'b0, pe});
      rd(8'h1E, v); chk("R7 after burst", v, 8'h07);

      // R1: reset in the middle of activity
      @(negedge clk); rst_n = 1'b0;
      #2;
      rd(8'h1D, v); chk("R1 dir re-reset", v, 8'h07);
      rd(8'h1F, v); chk("R1 out re-reset", v, 8'h00);
      rd(8'h1E, v); chk("R1 smp re-reset", v, 8'h00);
      chk("R1 oe re-reset", {5'b0, pin_oe}, 8'h00);
      @(negedge clk); rst_n = 1'b1;
      pin_in = 3'b000;
      repeat (2) @(negedge clk);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule